// File: doc/BRIEF.md
# Ternary CAM Lookup Engine

This block is a small ternary lookup table. Every entry holds a key pattern in which each bit is zero, one or wildcard, a valid flag, and a result word kept in an associated RAM. A search key is compared against every valid entry in the same cycle. The lowest-numbered matching entry wins, and its index addresses the result RAM. The engine returns the winning index, a hit flag and the result word. A typical use is a route table: longer prefixes are loaded at lower indices, so table order alone gives longest-prefix selection.

Software-side loading uses an address/data write port that stores pattern, valid flag and result together. An addressed read port returns what an entry holds. Searches are pipelined: a new key can be issued on every clock, and each answer appears two cycles after its key.

Top module: `tcam_lookup`

## Requirements
- R1: A write stores pattern, valid flag and result at the given address; a read presented on one cycle returns that entry's pattern, valid flag and result on the outputs after the next rising edge.
- R2: Each key bit i is coded in pattern bits [2i+1:2i] as a pair (hi, lo): 01 is zero, 10 is one, 00 is wildcard; 11 is illegal and is never held by a valid entry.
- R3: An entry matches only when every bit matches: a wildcard matches either key value, and a zero or one bit matches only an equal key bit.
- R4: An entry whose valid flag is clear never matches, whatever its pattern.
- R5: When several entries match, the lowest index is reported.
- R6: On a hit, the result output carries the result word stored at the winning index.
- R7: On a search with no match, the hit output is low, and the index and result outputs are zero.
- R8: A write whose pattern contains any 11 pair leaves the entry unchanged, and the error flag is high for exactly the cycle after the write.
- R9: Index, hit and result for a key appear, with the result-valid flag high, two rising edges after the key is presented; a key may be presented on every cycle.
- R10: After reset all entries are invalid and the search outputs, read outputs and error flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | IDX_W | Entry address for a write |
| wr_code | input | 2*KEY_W | Ternary pattern, two bits per key bit |
| wr_valid | input | 1 | Valid flag to store |
| wr_result | input | RES_W | Result word to store |
| wr_err | output | 1 | Illegal-pattern write was rejected |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | IDX_W | Entry address for a read |
| rd_code | output | 2*KEY_W | Pattern read back |
| rd_valid | output | 1 | Valid flag read back |
| rd_result | output | RES_W | Result word read back |
| srch_en | input | 1 | Search strobe |
| srch_key | input | KEY_W | Search key |
| res_vld | output | 1 | Search answer present |
| res_hit | output | 1 | Search found a match |
| res_idx | output | IDX_W | Winning entry index |
| res_data | output | RES_W | Result word of the winning entry |

## Verification
On every cycle the assertions hold that a valid entry never contains an illegal pair, that an invalid entry produces no match, that the reported index is a matching entry with no lower-numbered match, that a miss drives zeros, that a rejected write raises the error flag, and that an answer follows each key after two edges. Only the bench scenarios show that the ternary comparison gives the right answer for concrete keys, such as the overlapping prefix example where the shorter entry must lose. They also show that a rejected write truly leaves the stored entry intact and that the result word belongs to the winning index.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  // Per-bit ternary state code, {hi, lo}
  typedef enum logic [1:0] {
    TB_WILD = 2'b00,
    TB_ZERO = 2'b01,
    TB_ONE  = 2'b10,
    TB_BAD  = 2'b11
  } tbit_e;

  // Does one stored ternary bit accept the key bit?
  function automatic logic tbit_hit(input logic [1:0] code, input logic kbit);
    case (code)
      TB_WILD: tbit_hit = 1'b1;
      TB_ZERO: tbit_hit = ~kbit;
      TB_ONE:  tbit_hit = kbit;
      default: tbit_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tcam_entry_store.sv
module tcam_entry_store #(
  parameter int KEY_W = 8,
  parameter int DEPTH = 8,
  parameter int RES_W = 8,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CODE_W = 2 * KEY_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]       wr_code,
  input  logic                    wr_valid,
  input  logic [RES_W-1:0]        wr_result,
  output logic                    wr_err,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_addr,
  output logic [CODE_W-1:0]       rd_code,
  output logic                    rd_valid,
  output logic [RES_W-1:0]        rd_result,
  input  logic [IDX_W-1:0]        ram_addr,
  output logic [RES_W-1:0]        ram_word,
  output logic [DEPTH-1:0][CODE_W-1:0] tbl_code,
  output logic [DEPTH-1:0]        tbl_valid
);

  logic [DEPTH-1:0][CODE_W-1:0] code_q;
  logic [DEPTH-1:0][RES_W-1:0]  res_q;
  logic [DEPTH-1:0]             valid_q, valid_d;
  logic [KEY_W-1:0]             pair_bad;
  logic                         bad_wr, do_wr;
  logic                         err_d;
  logic [CODE_W-1:0]            rd_code_d;
  logic                         rd_valid_d;
  logic [RES_W-1:0]             rd_result_d;

  // Illegal-code detection on the incoming pattern
  for (genvar b = 0; b < KEY_W; b++) begin : g_pair
    assign pair_bad[b] = (wr_code[2*b +: 2] == tcam_pkg::TB_BAD);
  end

  always_comb begin
    bad_wr  = wr_en && (|pair_bad);
    do_wr   = wr_en && !bad_wr;
    err_d   = bad_wr;
    valid_d = valid_q;
    if (do_wr && (int'(wr_addr) < DEPTH)) valid_d[wr_addr] = wr_valid;
  end

  always_comb begin
    rd_code_d   = '0;
    rd_valid_d  = 1'b0;
    rd_result_d = '0;
    if (int'(rd_addr) < DEPTH) begin
      rd_code_d   = code_q[rd_addr];
      rd_valid_d  = valid_q[rd_addr];
      rd_result_d = res_q[rd_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= '0;
      wr_err    <= 1'b0;
      rd_code   <= '0;
      rd_valid  <= 1'b0;
      rd_result <= '0;
    end else begin
      valid_q <= valid_d;
      wr_err  <= err_d;
      if (rd_en) begin
        rd_code   <= rd_code_d;
        rd_valid  <= rd_valid_d;
        rd_result <= rd_result_d;
      end
    end
  end

  // Pattern and result storage: no reset, write-enabled per entry
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (do_wr && (int'(wr_addr) == e)) begin
        code_q[e] <= wr_code;
        res_q[e]  <= wr_result;
      end
    end

    // R2
    no_illegal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[e] |-> !(|(code_q[e] & (code_q[e] >> 1) & {KEY_W{2'b01}})));
  end

  assign ram_word  = (int'(ram_addr) < DEPTH) ? res_q[ram_addr] : '0;
  assign tbl_code  = code_q;
  assign tbl_valid = valid_q;

  // R8
  bad_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (|pair_bad)) |=> wr_err);

endmodule

// File: rtl/tcam_match_array.sv
module tcam_match_array #(
  parameter int KEY_W = 8,
  parameter int DEPTH = 8,
  localparam int CODE_W = 2 * KEY_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         srch_en,
  input  logic [KEY_W-1:0]             srch_key,
  input  logic [DEPTH-1:0][CODE_W-1:0] tbl_code,
  input  logic [DEPTH-1:0]             tbl_valid,
  output logic [DEPTH-1:0]             match_q,
  output logic                         s1_vld
);

  logic [DEPTH-1:0] match_d;

  for (genvar e = 0; e < DEPTH; e++) begin : g_row
    logic [KEY_W-1:0] bit_ok;
    for (genvar b = 0; b < KEY_W; b++) begin : g_col
      assign bit_ok[b] = tcam_pkg::tbit_hit(tbl_code[e][2*b +: 2], srch_key[b]);
    end
    assign match_d[e] = tbl_valid[e] && (&bit_ok);

    // R4
    invalid_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_en && !tbl_valid[e]) |=> !match_q[e]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      s1_vld  <= 1'b0;
    end else begin
      s1_vld <= srch_en;
      if (srch_en) match_q <= match_d;
    end
  end

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    any = |vec;
  end

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
  parameter int KEY_W = 8,
  parameter int DEPTH = 8,
  parameter int RES_W = 8,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CODE_W = 2 * KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_valid,
  input  logic [RES_W-1:0]  wr_result,
  output logic              wr_err,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [CODE_W-1:0] rd_code,
  output logic              rd_valid,
  output logic [RES_W-1:0]  rd_result,
  input  logic              srch_en,
  input  logic [KEY_W-1:0]  srch_key,
  output logic              res_vld,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_idx,
  output logic [RES_W-1:0]  res_data
);

  logic [DEPTH-1:0][CODE_W-1:0] tbl_code;
  logic [DEPTH-1:0]             tbl_valid;
  logic [DEPTH-1:0]             match_vec;
  logic                         s1_vld;
  logic [IDX_W-1:0]             win_idx;
  logic                         win_any;
  logic [RES_W-1:0]             ram_word;
  logic                         hit_d;
  logic [IDX_W-1:0]             idx_d;
  logic [RES_W-1:0]             data_d;

  tcam_entry_store #(.KEY_W(KEY_W), .DEPTH(DEPTH), .RES_W(RES_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
    .wr_valid(wr_valid), .wr_result(wr_result), .wr_err(wr_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_code(rd_code),
    .rd_valid(rd_valid), .rd_result(rd_result),
    .ram_addr(win_idx), .ram_word(ram_word),
    .tbl_code(tbl_code), .tbl_valid(tbl_valid)
  );

  tcam_match_array #(.KEY_W(KEY_W), .DEPTH(DEPTH)) match_i (
    .clk(clk), .rst_n(rst_n),
    .srch_en(srch_en), .srch_key(srch_key),
    .tbl_code(tbl_code), .tbl_valid(tbl_valid),
    .match_q(match_vec), .s1_vld(s1_vld)
  );

  tcam_prio_enc #(.DEPTH(DEPTH)) enc_i (
    .vec(match_vec), .idx(win_idx), .any(win_any)
  );

  // Stage 2 next-state
  always_comb begin
    hit_d  = win_any;
    idx_d  = win_any ? win_idx  : '0;
    data_d = win_any ? ram_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_hit  <= 1'b0;
      res_idx  <= '0;
      res_data <= '0;
    end else begin
      res_vld <= s1_vld;
      if (s1_vld) begin
        res_hit  <= hit_d;
        res_idx  <= idx_d;
        res_data <= data_d;
      end
    end
  end

  // R5
  prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && win_any) |->
      (match_vec[win_idx] &&
       ((match_vec & ((DEPTH'(1) << win_idx) - DEPTH'(1))) == '0)));

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_hit) |-> (res_data == '0 && res_idx == '0));

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> ##1 res_vld);

endmodule

// File: tb/tcam_lookup_tb_top.sv
`timescale 1ns/1ps
module tcam_lookup_tb_top;

  localparam int KW = 5;
  localparam int DP = 8;
  localparam int RW = 8;
  localparam int IW = 3;
  localparam int NV = 9;

  logic          clk, rst_n;
  logic          wr_en, wr_valid, wr_err;
  logic [IW-1:0] wr_addr, rd_addr, res_idx;
  logic [2*KW-1:0] wr_code, rd_code;
  logic [RW-1:0] wr_result, rd_result, res_data;
  logic          rd_en, rd_valid, srch_en, res_vld, res_hit;
  logic [KW-1:0] srch_key;

  int checks = 0;
  int errors = 0;

  tcam_lookup #(.KEY_W(KW), .DEPTH(DP), .RES_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
    .wr_valid(wr_valid), .wr_result(wr_result), .wr_err(wr_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_code(rd_code),
    .rd_valid(rd_valid), .rd_result(rd_result),
    .srch_en(srch_en), .srch_key(srch_key),
    .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx), .res_data(res_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Search vectors: key, expected hit, index, result
  localparam logic [KW-1:0] V_KEY [NV] = '{5'b01101, 5'b10100, 5'b10111, 5'b01110,
                                           5'b01111, 5'b10011, 5'b00000, 5'b11111, 5'b01100};
  localparam logic          V_HIT [NV] = '{1, 1, 1, 1, 1, 1, 0, 0, 1};
  localparam logic [IW-1:0] V_IDX [NV] = '{1, 0, 0, 2, 2, 3, 0, 0, 1};
  localparam logic [RW-1:0] V_DAT [NV] = '{8'h0B, 8'h0A, 8'h0A, 8'h0C, 8'h0C,
                                           8'h0D, 8'h00, 8'h00, 8'h0B};

  function automatic logic [2*KW-1:0] tern(input logic [KW-1:0] val, input logic [KW-1:0] care);
    logic [2*KW-1:0] c;
    for (int i = 0; i < KW; i++)
      c[2*i +: 2] = care[i] ? (val[i] ? 2'b10 : 2'b01) : 2'b00;
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [IW-1:0] a, input logic [2*KW-1:0] c,
                          input logic v, input logic [RW-1:0] r);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_code = c; wr_valid = v; wr_result = r;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [IW-1:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_search(input logic [KW-1:0] k);
    @(negedge clk);
    srch_en = 1'b1; srch_key = k;
    @(negedge clk);
    srch_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; srch_en = 1'b0;
    wr_addr = '0; wr_code = '0; wr_valid = 1'b0; wr_result = '0;
    rd_addr = '0; srch_key = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 res_vld", res_vld, 0);
    check("R10 res_hit", res_hit, 0);
    check("R10 res_data", res_data, 0);
    check("R10 wr_err", wr_err, 0);
    do_read(3'd2);
    check("R10 entry invalid", rd_valid, 0);
    do_search(5'b01101);
    check("R10 empty table miss", res_hit, 0);

    // Load route table (R2 encoding)
    do_write(3'd0, tern(5'b10100, 5'b11100), 1'b1, 8'h0A);
    do_write(3'd1, tern(5'b01100, 5'b11110), 1'b1, 8'h0B);
    do_write(3'd2, tern(5'b01100, 5'b11100), 1'b1, 8'h0C);
    do_write(3'd3, tern(5'b10011, 5'b11111), 1'b1, 8'h0D);

    // R1: read back
    do_read(3'd1);
    check("R1 code", rd_code, tern(5'b01100, 5'b11110));
    check("R1 valid", rd_valid, 1);
    check("R1 result", rd_result, 8'h0B);

    // Vector walk, one key per cycle (R3 R5 R6 R7 R9)
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R9 res_vld", res_vld, 1);
        check("R3 R5 hit", res_hit, V_HIT[i-2]);
        check("R5 index", res_idx, V_IDX[i-2]);
        check("R6 R7 result", res_data, V_DAT[i-2]);
      end
      if (i < NV) begin
        srch_en = 1'b1; srch_key = V_KEY[i];
      end else begin
        srch_en = 1'b0;
      end
    end
    @(negedge clk);
    check("R9 idle res_vld", res_vld, 0);

    // R8: illegal code rejected, entry unchanged, error one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_code = 10'b11_00_00_00_00;
    wr_valid = 1'b1; wr_result = 8'hEE;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 err raised", wr_err, 1);
    @(negedge clk);
    check("R8 err pulse", wr_err, 0);
    do_read(3'd0);
    check("R8 code kept", rd_code, tern(5'b10100, 5'b11100));
    check("R8 result kept", rd_result, 8'h0A);
    do_search(5'b10100);
    check("R8 search still A", res_data, 8'h0A);

    // R4: invalid wildcard entry never matches
    do_write(3'd4, tern(5'b00000, 5'b00000), 1'b0, 8'h44);
    do_search(5'b00000);
    check("R4 invalid no hit", res_hit, 0);
    check("R4 invalid zero data", res_data, 0);
    do_write(3'd4, tern(5'b00000, 5'b00000), 1'b1, 8'h44);
    do_search(5'b00000);
    check("R3 wildcard hit", res_hit, 1);
    check("R3 wildcard index", res_idx, 4);
    check("R6 wildcard result", res_data, 8'h44);
    do_search(5'b01101);
    check("R5 lower index beats wildcard", res_idx, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule